// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block produces the raster timing for a parallel TFT panel. Two counters drive it: a horizontal position that advances once per pixel clock and a line number that advances each time the horizontal position wraps. Every output is a comparator window over one of those counters. Each window is set by a 32-bit word that holds a start position and an end position. The outputs are horizontal sync, vertical sync, a data-enable that covers the active picture area, and a set of auxiliary panel-control pulses. Each auxiliary pulse can sit anywhere within a line.

Software writes the configuration words through a plain write port with a write strobe, an address and 32 data bits. The writes go into staging storage. A start request copies the staged set into the working set in one step and begins scanning from pixel (0,0). A stop request does not cut a frame short. The block finishes the frame in progress, then returns to idle, where the counters sit at zero and every output is low.

Top module: `tft_raster_gen`

## Requirements
- R1: While reset is asserted, and on the first cycles after it, every output (hsync, vsync, de, all aux bits) is low.
- R2: Every configuration word carries a start position in bits 31:16 and an end position in bits 15:0. The address map is: 0 is the totals (horizontal line total in the start half, vertical frame total in the end half), 1 is the hsync window, 2 is the vsync window, 3 is the horizontal active window, 4 is the vertical active window, and 5+i is auxiliary pulse i.
- R3: A window output is high exactly when start <= counter < end. A window with end <= start stays low at all times.
- R4: Hsync is the window over the horizontal position. Vsync is the window over the line number, so vsync holds its level for whole lines.
- R5: Data-enable is high only when both the horizontal active window and the vertical active window are high.
- R6: The horizontal position wraps to 0 after (horizontal total - 1). At that wrap the line number advances, and the line number wraps to 0 after (vertical total - 1). A frame therefore lasts htotal*vtotal cycles and repeats without a gap.
- R7: Each auxiliary pulse is an independent window over the horizontal position, and it repeats on every line.
- R8: A write changes only staging storage. The working values are loaded from staging only by a start request made while idle. A write made while scanning has no effect until the next start, and a start made while scanning is ignored.
- R9: While idle, the counters hold at zero and all outputs stay low. This holds during configuration writes and during a stop request made while idle.
- R10: A stop request made while scanning takes effect after the last pixel of the current frame. A stop made on that last pixel takes effect immediately after it.
- R11: Outputs are registered. The output for counter position (h,v) appears one clock after the counters hold it. The clock edge that accepts a start leaves the outputs low, and pixel (0,0) appears on the following edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | AW | Configuration word address |
| cfg_wdata | input | 32 | Configuration word: start in 31:16, end in 15:0 |
| ctl_start | input | 1 | Start request; loads the working set when idle |
| ctl_stop | input | 1 | Stop request; takes effect at the end of the frame |
| lcd_hsync | output | 1 | Horizontal sync window |
| lcd_vsync | output | 1 | Vertical sync window |
| lcd_de | output | 1 | Data-enable for the active area |
| lcd_aux | output | NAUX | Auxiliary panel-control pulses |

## Verification
The main test compares every pixel of whole frames against a position model, using two different sets of totals. This separates the horizontal wrap from the vertical wrap, and a frame that repeats from one that restarts wrongly. The first configuration includes a normal auxiliary window, an empty window (end equal to start), an inverted window (end below start) and a window ending at the line total. These tell the comparator bounds apart from off-by-one variants. Staged writes made while scanning, a start made while scanning, and stops made at mid-frame, on the last pixel and while idle separate the working set from the staging set, and a frame-boundary stop from an immediate one.

// File: rtl/tg_pkg.sv
package tg_pkg;

   // One configuration word: start position in the upper half, end in the lower half.
   typedef struct packed {
      logic [15:0] first;
      logic [15:0] last;
   } tg_span_t;

   localparam int TG_SLOT_TOTALS = 0;
   localparam int TG_SLOT_HSYNC  = 1;
   localparam int TG_SLOT_VSYNC  = 2;
   localparam int TG_SLOT_HACT   = 3;
   localparam int TG_SLOT_VACT   = 4;
   localparam int TG_SLOT_AUX0   = 5;

endpackage

// File: rtl/tg_regfile.sv
module tg_regfile
   import tg_pkg::*;
#(
   parameter int NAUX = 4,
   parameter int AW   = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [31:0]   wr_data,
   input  logic          commit,
   output tg_span_t      tot_q,
   output tg_span_t      hs_q,
   output tg_span_t      vs_q,
   output tg_span_t      ha_q,
   output tg_span_t      va_q,
   output tg_span_t      aux_q [NAUX]
);

   localparam int NSLOT = TG_SLOT_AUX0 + NAUX;

   generate
      if (NSLOT > (1 << AW)) begin : g_bad_aw
         $error("tg_regfile: AW too narrow for %0d slots", NSLOT);
      end
   endgenerate

   tg_span_t stg [NSLOT];
   tg_span_t act [NSLOT];

   genvar gi;
   generate
      for (gi = 0; gi < NSLOT; gi++) begin : g_slot
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               stg[gi] <= '0;
               act[gi] <= '0;
            end else begin
               if (wr_en && (wr_addr == AW'(gi)))
                  stg[gi] <= wr_data;
               if (commit)
                  act[gi] <= stg[gi];
            end
         end

         // R8: working values move only on a commit
         assert_working_set_held_R8 : assert property (
            @(posedge clk) disable iff (!rst_n)
            !commit |=> $stable(act[gi]));
      end

      for (gi = 0; gi < NAUX; gi++) begin : g_aux_out
         assign aux_q[gi] = act[TG_SLOT_AUX0 + gi];
      end
   endgenerate

   assign tot_q = act[TG_SLOT_TOTALS];
   assign hs_q  = act[TG_SLOT_HSYNC];
   assign vs_q  = act[TG_SLOT_VSYNC];
   assign ha_q  = act[TG_SLOT_HACT];
   assign va_q  = act[TG_SLOT_VACT];

endmodule

// File: rtl/tg_axis.sv
module tg_axis #(
   parameter int CW = 12
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   input  logic          step,
   input  logic [15:0]   limit,
   output logic [CW-1:0] cnt,
   output logic          wrap
);

   logic [16:0] nxt;

   assign nxt  = {1'b0, 16'(cnt)} + 17'd1;
   assign wrap = (nxt >= {1'b0, limit});

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt <= '0;
      else if (!run)
         cnt <= '0;
      else if (step)
         cnt <= wrap ? '0 : cnt + CW'(1);
   end

   // R6: a wrapping step returns the counter to zero
   assert_wrap_to_zero_R6 : assert property (
      @(posedge clk) disable iff (!rst_n)
      (run && step && wrap) |=> (cnt == '0));

   // R6: the counter stays below a non-zero total while scanning
   assert_count_in_range_R6 : assert property (
      @(posedge clk) disable iff (!rst_n)
      (run && (limit != 16'd0) && (limit <= 16'(1 << (CW - 1)))) |->
         ({1'b0, 16'(cnt)} < {1'b0, limit}));

   // R9: idle forces the counter to zero
   assert_idle_counter_zero_R9 : assert property (
      @(posedge clk) disable iff (!rst_n)
      !run |=> (cnt == '0));

endmodule

// File: rtl/tg_window.sv
module tg_window
   import tg_pkg::*;
#(
   parameter int CW = 12
) (
   input  logic [CW-1:0] pos,
   input  tg_span_t      span,
   output logic          hit
);

   logic [15:0] p16;

   assign p16 = 16'(pos);
   assign hit = (p16 >= span.first) && (p16 < span.last);

endmodule

// File: rtl/tg_ctrl.sv
module tg_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic stop,
   input  logic frame_end,
   output logic run,
   output logic commit
);

   logic pend;
   logic run_n;
   logic pend_n;

   assign commit = start & ~run;

   always_comb begin
      run_n  = run;
      pend_n = pend;
      if (!run) begin
         run_n  = start;
         pend_n = 1'b0;
      end else if (frame_end && (pend || stop)) begin
         run_n  = 1'b0;
         pend_n = 1'b0;
      end else if (stop) begin
         pend_n = 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run  <= 1'b0;
         pend <= 1'b0;
      end else begin
         run  <= run_n;
         pend <= pend_n;
      end
   end

   // R10: scanning never halts inside a frame
   assert_no_midframe_halt_R10 : assert property (
      @(posedge clk) disable iff (!rst_n)
      (run && !frame_end) |=> run);

   // R8: idle leaves only through a start request
   assert_idle_needs_start_R8 : assert property (
      @(posedge clk) disable iff (!rst_n)
      (!run && !start) |=> !run);

endmodule

// File: rtl/tft_raster_gen.sv
module tft_raster_gen
   import tg_pkg::*;
#(
   parameter int CW      = 12,
   parameter int NAUX    = 4,
   parameter int AW      = 4,
   parameter bit OUT_REG = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cfg_we,
   input  logic [AW-1:0]   cfg_addr,
   input  logic [31:0]     cfg_wdata,
   input  logic            ctl_start,
   input  logic            ctl_stop,
   output logic            lcd_hsync,
   output logic            lcd_vsync,
   output logic            lcd_de,
   output logic [NAUX-1:0] lcd_aux
);

   localparam int OW = 3 + NAUX;

   generate
      if (CW < 2 || CW > 16) begin : g_bad_cw
         $error("tft_raster_gen: CW must be 2..16");
      end
      if (NAUX < 1 || NAUX > 8) begin : g_bad_naux
         $error("tft_raster_gen: NAUX must be 1..8");
      end
   endgenerate

   tg_span_t tot, hs_w, vs_w, ha_w, va_w;
   tg_span_t aux_w [NAUX];

   logic          run, commit;
   logic [CW-1:0] hpos, vpos;
   logic          h_wrap, v_wrap;
   logic          hs_hit, vs_hit, ha_hit, va_hit;
   logic [NAUX-1:0] aux_hit;
   logic [OW-1:0] raw, outv;

   tg_ctrl u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (ctl_start),
      .stop      (ctl_stop),
      .frame_end (h_wrap & v_wrap),
      .run       (run),
      .commit    (commit)
   );

   tg_regfile #(.NAUX(NAUX), .AW(AW)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (cfg_we),
      .wr_addr (cfg_addr),
      .wr_data (cfg_wdata),
      .commit  (commit),
      .tot_q   (tot),
      .hs_q    (hs_w),
      .vs_q    (vs_w),
      .ha_q    (ha_w),
      .va_q    (va_w),
      .aux_q   (aux_w)
   );

   tg_axis #(.CW(CW)) u_hcnt (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (run),
      .step  (1'b1),
      .limit (tot.first),
      .cnt   (hpos),
      .wrap  (h_wrap)
   );

   tg_axis #(.CW(CW)) u_vcnt (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (run),
      .step  (h_wrap),
      .limit (tot.last),
      .cnt   (vpos),
      .wrap  (v_wrap)
   );

   tg_window #(.CW(CW)) u_hs (.pos(hpos), .span(hs_w), .hit(hs_hit));
   tg_window #(.CW(CW)) u_vs (.pos(vpos), .span(vs_w), .hit(vs_hit));
   tg_window #(.CW(CW)) u_ha (.pos(hpos), .span(ha_w), .hit(ha_hit));
   tg_window #(.CW(CW)) u_va (.pos(vpos), .span(va_w), .hit(va_hit));

   genvar gi;
   generate
      for (gi = 0; gi < NAUX; gi++) begin : g_aux
         tg_window #(.CW(CW)) u_aux (
            .pos  (hpos),
            .span (aux_w[gi]),
            .hit  (aux_hit[gi])
         );
      end
   endgenerate

   assign raw = {aux_hit, ha_hit & va_hit, vs_hit, hs_hit};

   generate
      if (OUT_REG) begin : g_out_reg
         always_ff @(posedge clk) begin
            if (!rst_n)
               outv <= '0;
            else
               outv <= run ? raw : '0;
         end

         // R9: an idle cycle is followed by quiet outputs
         assert_quiet_when_idle_R9 : assert property (
            @(posedge clk) disable iff (!rst_n)
            !run |=> (outv == '0));

         // R1: outputs leave reset low
         assert_reset_quiet_R1 : assert property (
            @(posedge clk)
            !rst_n |=> (outv == '0));
      end else begin : g_out_comb
         assign outv = run ? raw : '0;
      end
   endgenerate

   assign lcd_hsync = outv[0];
   assign lcd_vsync = outv[1];
   assign lcd_de    = outv[2];
   assign lcd_aux   = outv[OW-1:3];

endmodule

// File: tb/tb_tft_raster_gen.sv
`timescale 1ns/1ps
module tb_tft_raster_gen;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [3:0]  cfg_addr = '0;
   logic [31:0] cfg_wdata = '0;
   logic        ctl_start = 1'b0;
   logic        ctl_stop = 1'b0;
   logic        lcd_hsync, lcd_vsync, lcd_de;
   logic [3:0]  lcd_aux;

   always #4 clk = ~clk;

   tft_raster_gen dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_addr  (cfg_addr),
      .cfg_wdata (cfg_wdata),
      .ctl_start (ctl_start),
      .ctl_stop  (ctl_stop),
      .lcd_hsync (lcd_hsync),
      .lcd_vsync (lcd_vsync),
      .lcd_de    (lcd_de),
      .lcd_aux   (lcd_aux)
   );

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   logic [31:0] stg [9];
   logic [31:0] act [9];
   bit brun = 1'b0;
   bit bpend = 1'b0;
   int pix = 0;

   function automatic bit inwin(int p, logic [31:0] w);
      return (p >= int'(w[31:16])) && (p < int'(w[15:0]));
   endfunction

   function automatic int frame_len();
      return int'(act[0][31:16]) * int'(act[0][15:0]);
   endfunction

   // Expected {aux[3:0], de, vsync, hsync} for linear pixel index p (R3..R7)
   function automatic logic [6:0] model(int p);
      int ht = int'(act[0][31:16]);
      int h = p % ht;
      int v = p / ht;
      logic [6:0] e;
      e[0] = inwin(h, act[1]);
      e[1] = inwin(v, act[2]);
      e[2] = inwin(h, act[3]) && inwin(v, act[4]);
      for (int i = 0; i < 4; i++) e[3+i] = inwin(h, act[5+i]);
      return e;
   endfunction

   task automatic check(string req, logic [6:0] got, logic [6:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: pixel %0d got %b expected %b", req, pix, got, exp);
      end
   endtask

   // One clock; inputs set before it are sampled at its rising edge.
   task automatic step(string req);
      logic [6:0] exp;
      @(negedge clk);
      cfg_we = 1'b0;
      ctl_start = 1'b0;
      ctl_stop = 1'b0;
      exp = brun ? model(pix) : 7'd0;
      check(req, {lcd_aux, lcd_de, lcd_vsync, lcd_hsync}, exp);
      if (brun) begin
         pix++;
         if (pix == frame_len()) begin
            pix = 0;
            if (bpend) begin
               brun = 1'b0;
               bpend = 1'b0;
            end
         end
      end
   endtask

   task automatic wr(int a, logic [15:0] s, logic [15:0] e);
      cfg_we = 1'b1;
      cfg_addr = a[3:0];
      cfg_wdata = {s, e};
      stg[a] = {s, e};
   endtask

   task automatic go(string req);
      ctl_start = 1'b1;
      step(req);
      brun = 1'b1;
      pix = 0;
      foreach (act[i]) act[i] = stg[i];
   endtask

   task automatic halt();
      ctl_stop = 1'b1;
      if (brun) bpend = 1'b1;
   endtask

   task automatic t_reset();
      repeat (3) step("R1 outputs low in reset");
      rst_n = 1'b1;
      repeat (2) step("R1 outputs low after reset");
   endtask

   task automatic t_config_idle();
      wr(0, 16'd10, 16'd6); step("R9 idle during write");
      wr(1, 16'd0, 16'd2);  step("R9 idle during write");
      wr(2, 16'd0, 16'd1);  step("R9 idle during write");
      wr(3, 16'd3, 16'd8);  step("R9 idle during write");
      wr(4, 16'd2, 16'd5);  step("R9 idle during write");
      wr(5, 16'd1, 16'd2);  step("R9 idle during write");
      wr(6, 16'd4, 16'd4);  step("R9 idle during write");
      wr(7, 16'd7, 16'd10); step("R9 idle during write");
      wr(8, 16'd8, 16'd3);  step("R9 idle during write");
      halt(); step("R9 stop while idle ignored");
      step("R9 stop while idle ignored");
   endtask

   task automatic t_frame();
      go("R11 start edge leaves outputs low");
      repeat (frame_len()) step("R2 R3 R4 R5 R7 R11 first frame");
      repeat (frame_len()) step("R6 second frame repeats");
   endtask

   task automatic t_stage();
      ctl_start = 1'b1; step("R8 start while scanning ignored");
      wr(1, 16'd0, 16'd5); step("R8 staged hsync write invisible");
      wr(5, 16'd5, 16'd9); step("R8 staged aux write invisible");
      for (int g = 0; g < 200 && pix != 0; g++) step("R8 rest of frame on old values");
      halt();
      for (int g = 0; g < 200 && brun; g++) step("R10 frame completes after stop");
      repeat (4) step("R10 idle after stop");
      go("R11 restart edge quiet");
      repeat (frame_len()) step("R8 new values after restart");
   endtask

   task automatic t_stop_last();
      for (int g = 0; g < 200 && pix != frame_len() - 1; g++) step("R6 run to last pixel");
      halt();
      step("R10 stop on last pixel");
      repeat (3) step("R10 immediate idle after last pixel stop");
   endtask

   task automatic t_alt_totals();
      wr(0, 16'd7, 16'd4); step("R9 idle");
      wr(1, 16'd0, 16'd1); step("R9 idle");
      wr(2, 16'd0, 16'd2); step("R9 idle");
      wr(3, 16'd2, 16'd6); step("R9 idle");
      wr(4, 16'd1, 16'd3); step("R9 idle");
      wr(5, 16'd0, 16'd7); step("R9 idle");
      wr(6, 16'd6, 16'd7); step("R9 idle");
      wr(7, 16'd3, 16'd4); step("R9 idle");
      wr(8, 16'd2, 16'd2); step("R9 idle");
      go("R11 start edge quiet");
      repeat (2 * frame_len()) step("R6 R2 alternate totals");
      repeat (5) step("R6 mid-frame");
      halt();
      for (int g = 0; g < 200 && brun; g++) step("R10 mid-frame stop waits for frame end");
      repeat (4) step("R10 idle after mid-frame stop");
   endtask

   initial begin
      foreach (stg[i]) begin
         stg[i] = '0;
         act[i] = '0;
      end
      t_reset();
      t_config_idle();
      t_frame();
      t_stage();
      t_stop_last();
      t_alt_totals();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule